// File: doc/BRIEF.md
# Linear-Gap Local Alignment Scoring Array

The block scores local alignments with a linear gap cost. It is a chain of identical scoring elements, and each element stands for one position of a query sequence. Before a scan begins, each element receives a substitution-score column: the score of its query symbol paired with every possible subject symbol. A single gap cost is also written, and every element keeps its own copy of it. Subject symbols then enter the first element at up to one per clock, already encoded as lookup addresses into those columns. They move one element per clock along the chain.

Each element evaluates one cell of the dynamic-programming matrix per symbol. The cell score is the largest of four values: zero, the element's own previous score minus the gap cost, the score from the preceding element minus the gap cost, and the preceding element's earlier score plus the substitution score. A running maximum travels with each symbol. When the last symbol of a subject leaves the final element, the block presents the best local alignment score for that subject. Subjects may follow each other with no idle cycle between them. Queries shorter than the chain are handled by filling the columns of the unused elements with zeros.

Top module: `lingap_scan_array`

## Requirements
- R1: Every cell score equals max(0, own previous score − gap, upstream score − gap, upstream previous score + substitution score), with the gap cost shared by all elements.
- R2: The first row and the first column of every subject's matrix are zero, so each subject is scored independently, including when subjects arrive back to back.
- R3: After reset, res_valid is 0 and res_score is 0. Each subject produces exactly one res_valid pulse, and results come out in the order the subjects arrived. The pulse is visible NUM_PE clock edges after the edge that samples the subject's last symbol (sub_last=1).
- R4: res_score is the maximum cell score over the whole matrix of that subject against the loaded query.
- R5: All score arithmetic saturates at 2^SCORE_W − 1 and never wraps. The floor at zero bounds it from below.
- R6: A query shorter than NUM_PE gives the same score as the alignment against the query alone when the columns of the unused elements hold zeros.
- R7: Writing with cfg_col_we=1 stores cfg_col_score at row cfg_col_sym of the column in element cfg_col_pe. Element 0 holds the first query position and is nearest the input. Writing with cfg_gap_we=1 sets the gap cost in every element. Subject symbols are row addresses into those columns; the bench encodes A=0, C=1, G=2, T=3.
- R8: Cycles with sub_valid=0, whether inside a subject or between subjects, do not change any score.
- R9: With gap 1, match +2 and mismatch −1, the sequences GTCTATCAC and ATCTCGTATGATG give a best score of 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_col_we | input | 1 | Write one substitution-column entry |
| cfg_col_pe | input | PE_W | Element index for the column write |
| cfg_col_sym | input | SYM_W | Subject-symbol row for the column write |
| cfg_col_score | input | SUB_W | Signed substitution score to store |
| cfg_gap_we | input | 1 | Load the gap cost into all elements |
| cfg_gap | input | SCORE_W | Gap cost (unsigned) |
| sub_valid | input | 1 | Subject symbol present this cycle |
| sub_sym | input | SYM_W | Encoded subject symbol |
| sub_last | input | 1 | Marks the final symbol of a subject |
| res_valid | output | 1 | Result for one subject present |
| res_score | output | SCORE_W | Best local alignment score of that subject |

## Verification
The assertions assume that the gap cost and the columns stay unchanged while a subject is in flight. They also assume that no more than NUM_PE subject ends are outstanding at once. The stimulus meets both conditions: it reconfigures only after every expected result has come out, and the chain can never hold more subject ends than it has elements. Random queries, gap costs, match and mismatch scores, subject lengths and idle gaps are checked against a sequential model of the recurrence in the bench. A narrow second instance forces the saturation path, and directed cases cover the known-score pair, idle cycles and back-to-back subjects.

// File: rtl/lingap_pkg.sv
package lingap_pkg;
  // Widest of two sizes, used to pick a signed working width for sums.
  function automatic int wider(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lingap_subst_col.sv
module lingap_subst_col #(
  parameter int SYM_W = 2,
  parameter int SUB_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [SYM_W-1:0]        waddr,
  input  logic signed [SUB_W-1:0] wdata,
  input  logic [SYM_W-1:0]        raddr,
  output logic signed [SUB_W-1:0] rdata
);
  localparam int DEPTH = 1 << SYM_W;

  logic signed [SUB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lingap_cell.sv
module lingap_cell
  import lingap_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int PE_W    = 4,
  parameter int SYM_W   = 2,
  parameter int SUB_W   = 8,
  parameter int SCORE_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_col_we,
  input  logic [PE_W-1:0]         cfg_col_pe,
  input  logic [SYM_W-1:0]        cfg_col_sym,
  input  logic signed [SUB_W-1:0] cfg_col_score,
  input  logic                    cfg_gap_we,
  input  logic [SCORE_W-1:0]      cfg_gap,
  input  logic                    in_valid,
  input  logic                    in_last,
  input  logic [SYM_W-1:0]        in_sym,
  input  logic [SCORE_W-1:0]      in_h,
  input  logic [SCORE_W-1:0]      in_max,
  output logic                    out_valid,
  output logic                    out_last,
  output logic [SYM_W-1:0]        out_sym,
  output logic [SCORE_W-1:0]      out_h,
  output logic [SCORE_W-1:0]      out_max
);
  localparam int EXT = wider(SCORE_W, SUB_W) + 2;
  localparam logic [SCORE_W-1:0] SMAX = '1;

  logic [SCORE_W-1:0]      gap_q;
  logic [SCORE_W-1:0]      diag_q;
  logic                    fresh_q;
  logic                    col_we;
  logic signed [SUB_W-1:0] sub_sc;

  assign col_we = cfg_col_we && (cfg_col_pe == PE_W'(IDX));

  lingap_subst_col #(.SYM_W(SYM_W), .SUB_W(SUB_W)) u_col (
    .clk   (clk),
    .we    (col_we),
    .waddr (cfg_col_sym),
    .wdata (cfg_col_score),
    .raddr (in_sym),
    .rdata (sub_sc)
  );

  logic [SCORE_W-1:0]    diag_eff, left_eff, max_prev;
  logic signed [EXT-1:0] d_sum;
  logic [SCORE_W-1:0]    d_sat, left_gap, up_gap, h_new, m_new;

  always_comb begin
    // A fresh subject sees zeros on its first column.
    diag_eff = fresh_q ? '0 : diag_q;
    left_eff = fresh_q ? '0 : out_h;
    max_prev = fresh_q ? '0 : out_max;

    d_sum = $signed({{(EXT-SCORE_W){1'b0}}, diag_eff})
          + $signed({{(EXT-SUB_W){sub_sc[SUB_W-1]}}, sub_sc});
    if (d_sum < 0)
      d_sat = '0;
    else if (d_sum > $signed({{(EXT-SCORE_W){1'b0}}, SMAX}))
      d_sat = SMAX;
    else
      d_sat = d_sum[SCORE_W-1:0];

    left_gap = (left_eff > gap_q) ? (left_eff - gap_q) : '0;
    up_gap   = (in_h > gap_q) ? (in_h - gap_q) : '0;

    h_new = d_sat;
    if (left_gap > h_new) h_new = left_gap;
    if (up_gap > h_new)   h_new = up_gap;

    m_new = h_new;
    if (in_max > m_new)   m_new = in_max;
    if (max_prev > m_new) m_new = max_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q     <= '0;
      diag_q    <= '0;
      fresh_q   <= 1'b1;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_sym   <= '0;
      out_h     <= '0;
      out_max   <= '0;
    end else begin
      if (cfg_gap_we) gap_q <= cfg_gap;
      out_valid <= in_valid;
      if (in_valid) begin
        out_last <= in_last;
        out_sym  <= in_sym;
        out_h    <= h_new;
        out_max  <= m_new;
        diag_q   <= in_h;
        fresh_q  <= in_last;
      end
    end
  end

  // R1: along a subject, a cell score drops by at most the gap cost per column.
  a_r1_gap_step: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(out_valid) && !$past(out_last)
      |-> ({1'b0, out_h} + {1'b0, gap_q}) >= {1'b0, $past(out_h)});

  // R4: the carried maximum always covers the cell score it travels with.
  a_r4_max_cover: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_max >= out_h);

  // R4: within a subject the running maximum never falls.
  a_r4_max_monotone: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(out_valid) && !$past(out_last)
      |-> out_max >= $past(out_max));
endmodule

// File: rtl/lingap_scan_array.sv
module lingap_scan_array #(
  parameter int NUM_PE  = 16,
  parameter int SYM_W   = 2,
  parameter int SUB_W   = 8,
  parameter int SCORE_W = 16,
  localparam int PE_W   = (NUM_PE > 1) ? $clog2(NUM_PE) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_col_we,
  input  logic [PE_W-1:0]         cfg_col_pe,
  input  logic [SYM_W-1:0]        cfg_col_sym,
  input  logic signed [SUB_W-1:0] cfg_col_score,
  input  logic                    cfg_gap_we,
  input  logic [SCORE_W-1:0]      cfg_gap,
  input  logic                    sub_valid,
  input  logic [SYM_W-1:0]        sub_sym,
  input  logic                    sub_last,
  output logic                    res_valid,
  output logic [SCORE_W-1:0]      res_score
);
  localparam int CNT_W = $clog2(NUM_PE + 1) + 1;

  logic               v_ch [NUM_PE+1];
  logic               l_ch [NUM_PE+1];
  logic [SYM_W-1:0]   s_ch [NUM_PE+1];
  logic [SCORE_W-1:0] h_ch [NUM_PE+1];
  logic [SCORE_W-1:0] m_ch [NUM_PE+1];

  // Row zero of the matrix and an empty maximum enter at the head.
  assign v_ch[0] = sub_valid;
  assign l_ch[0] = sub_last;
  assign s_ch[0] = sub_sym;
  assign h_ch[0] = '0;
  assign m_ch[0] = '0;

  for (genvar g = 0; g < NUM_PE; g++) begin : g_cell
    lingap_cell #(
      .IDX(g), .PE_W(PE_W), .SYM_W(SYM_W), .SUB_W(SUB_W), .SCORE_W(SCORE_W)
    ) u_cell (
      .clk           (clk),
      .rst           (rst),
      .cfg_col_we    (cfg_col_we),
      .cfg_col_pe    (cfg_col_pe),
      .cfg_col_sym   (cfg_col_sym),
      .cfg_col_score (cfg_col_score),
      .cfg_gap_we    (cfg_gap_we),
      .cfg_gap       (cfg_gap),
      .in_valid      (v_ch[g]),
      .in_last       (l_ch[g]),
      .in_sym        (s_ch[g]),
      .in_h          (h_ch[g]),
      .in_max        (m_ch[g]),
      .out_valid     (v_ch[g+1]),
      .out_last      (l_ch[g+1]),
      .out_sym       (s_ch[g+1]),
      .out_h         (h_ch[g+1]),
      .out_max       (m_ch[g+1])
    );
  end

  assign res_valid = v_ch[NUM_PE] && l_ch[NUM_PE];
  assign res_score = m_ch[NUM_PE];

  // Count of subject ends that have entered but not yet been reported.
  logic [CNT_W-1:0] pending;
  logic             end_in;
  assign end_in = sub_valid && sub_last;

  always_ff @(posedge clk) begin
    if (rst) pending <= '0;
    else if (end_in && !res_valid) pending <= pending + 1'b1;
    else if (!end_in && res_valid) pending <= pending - 1'b1;
  end

  // R3: a result only appears for a subject whose end was accepted.
  a_r3_result_owed: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> pending != '0);

  // R3: the chain never holds more subject ends than it has elements.
  a_r3_pending_bound: assert property (@(posedge clk) disable iff (rst)
    pending <= CNT_W'(NUM_PE));

  // R4: the reported maximum covers the final cell score.
  a_r4_res_cover: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> res_score >= h_ch[NUM_PE]);
endmodule

// File: tb/lingap_scan_array_tb.sv
module lingap_scan_array_tb;
  localparam int NUM_PE = 16;
  localparam int SYM_W  = 2;
  localparam int SUB_W  = 8;
  localparam int SW_W   = 16;
  localparam int NW_W   = 5;
  localparam int PE_W   = $clog2(NUM_PE);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_col_we = 1'b0;
  logic [PE_W-1:0] cfg_col_pe = '0;
  logic [SYM_W-1:0] cfg_col_sym = '0;
  logic signed [SUB_W-1:0] cfg_col_score = '0;
  logic cfg_gap_we = 1'b0;
  logic [SW_W-1:0] cfg_gap = '0;
  logic sub_valid = 1'b0;
  logic [SYM_W-1:0] sub_sym = '0;
  logic sub_last = 1'b0;
  logic res_valid, res_valid_n;
  logic [SW_W-1:0] res_score;
  logic [NW_W-1:0] res_score_n;

  always #10 clk = ~clk;

  lingap_scan_array #(.NUM_PE(NUM_PE), .SYM_W(SYM_W), .SUB_W(SUB_W), .SCORE_W(SW_W)) u_dut (
    .clk(clk), .rst(rst), .cfg_col_we(cfg_col_we), .cfg_col_pe(cfg_col_pe),
    .cfg_col_sym(cfg_col_sym), .cfg_col_score(cfg_col_score), .cfg_gap_we(cfg_gap_we),
    .cfg_gap(cfg_gap), .sub_valid(sub_valid), .sub_sym(sub_sym), .sub_last(sub_last),
    .res_valid(res_valid), .res_score(res_score));

  lingap_scan_array #(.NUM_PE(NUM_PE), .SYM_W(SYM_W), .SUB_W(SUB_W), .SCORE_W(NW_W)) u_sat (
    .clk(clk), .rst(rst), .cfg_col_we(cfg_col_we), .cfg_col_pe(cfg_col_pe),
    .cfg_col_sym(cfg_col_sym), .cfg_col_score(cfg_col_score), .cfg_gap_we(cfg_gap_we),
    .cfg_gap(cfg_gap[NW_W-1:0]), .sub_valid(sub_valid), .sub_sym(sub_sym), .sub_last(sub_last),
    .res_valid(res_valid_n), .res_score(res_score_n));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int qry [32];
  int subj [64];
  int qlen, gap, mt, mm;
  int exp_w [$];
  int exp_n [$];
  int exp_c [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sequential model of the linear-gap recurrence with saturation at mx.
  function automatic int model(input int sl, input int mx);
    int prev [33];
    int cur [33];
    int best, d, a, u, h;
    best = 0;
    for (int i = 0; i <= 32; i++) prev[i] = 0;
    for (int j = 0; j < sl; j++) begin
      cur[0] = 0;
      for (int i = 1; i <= qlen; i++) begin
        d = prev[i-1] + ((qry[i-1] == subj[j]) ? mt : mm);
        if (d < 0) d = 0;
        if (d > mx) d = mx;
        a = prev[i] - gap;
        u = cur[i-1] - gap;
        h = d;
        if (a > h) h = a;
        if (u > h) h = u;
        cur[i] = h;
        if (h > best) best = h;
      end
      for (int i = 0; i <= 32; i++) prev[i] = cur[i];
    end
    return best;
  endfunction

  function automatic int enc(input byte c);
    case (c)
      "A": return 0;
      "C": return 1;
      "G": return 2;
      default: return 3;
    endcase
  endfunction

  // R7, R6: column writes per element; unused elements get zero columns.
  task automatic load_query();
    for (int p = 0; p < NUM_PE; p++) begin
      for (int s = 0; s < (1 << SYM_W); s++) begin
        @(negedge clk);
        cfg_col_we = 1'b1;
        cfg_col_pe = PE_W'(p);
        cfg_col_sym = SYM_W'(s);
        cfg_col_score = (p < qlen) ? SUB_W'((qry[p] == s) ? mt : mm) : '0;
      end
    end
    @(negedge clk);
    cfg_col_we = 1'b0;
    cfg_gap_we = 1'b1;
    cfg_gap = SW_W'(gap);
    @(negedge clk);
    cfg_gap_we = 1'b0;
  endtask

  // Leaves sub_valid high after the last symbol so a following call is back to back.
  task automatic send(input int sl, input bit idles);
    exp_w.push_back(model(sl, (1 << SW_W) - 1));
    exp_n.push_back(model(sl, (1 << NW_W) - 1));
    for (int j = 0; j < sl; j++) begin
      @(negedge clk);
      if (idles && ($urandom % 3 == 0)) begin
        sub_valid = 1'b0;
        sub_last = 1'b0;
        @(negedge clk);
      end
      sub_valid = 1'b1;
      sub_sym = SYM_W'(subj[j]);
      sub_last = (j == sl - 1);
      if (j == sl - 1) exp_c.push_back(cyc);
    end
  endtask

  task automatic idle_and_drain();
    @(negedge clk);
    sub_valid = 1'b0;
    sub_last = 1'b0;
    while (exp_w.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Result monitor, sampling mid-way through the high phase.
  always @(posedge clk) begin
    #5;
    if (!rst && res_valid) begin
      if (exp_w.size() == 0) begin
        check("R3 unexpected result", 1, 0);
      end else begin
        check("R4 R1 score", int'(res_score), exp_w.pop_front());
        check("R5 saturated score", int'(res_score_n), exp_n.pop_front());
        check("R3 latency", cyc - exp_c.pop_front(), NUM_PE);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R3 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    string qs, ss;
    int sl;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R3: reset state
    check("R3 reset res_valid", int'(res_valid), 0);
    check("R3 reset res_score", int'(res_score), 0);

    // R9, R7, R6: directed known pair, query padded within the chain
    qs = "GTCTATCAC";
    ss = "ATCTCGTATGATG";
    qlen = qs.len();
    for (int i = 0; i < qlen; i++) qry[i] = enc(qs.getc(i));
    sl = ss.len();
    for (int j = 0; j < sl; j++) subj[j] = enc(ss.getc(j));
    gap = 1; mt = 2; mm = -1;
    load_query();
    check("R9 model of directed pair", model(sl, 65535), 10);
    send(sl, 1'b0);
    idle_and_drain();
    // R8: same pair with idle cycles inside the subject
    send(sl, 1'b1);
    idle_and_drain();
    // R2: three subjects back to back, the directed one between random ones
    for (int k = 0; k < 3; k++) begin
      if (k != 1) for (int j = 0; j < sl; j++) subj[j] = $urandom % 4;
      else for (int j = 0; j < sl; j++) subj[j] = enc(ss.getc(j));
      send(sl, 1'b0);
    end
    idle_and_drain();

    // R5: identical long match drives the narrow instance to its ceiling
    qlen = NUM_PE; gap = 2; mt = 5; mm = -3;
    for (int i = 0; i < qlen; i++) qry[i] = 0;
    load_query();
    for (int j = 0; j < 30; j++) subj[j] = 0;
    check("R5 model reaches ceiling", model(30, 31), 31);
    send(30, 1'b0);
    idle_and_drain();

    // R1, R2, R4, R6, R8: random queries and subjects
    for (int t = 0; t < 25; t++) begin
      qlen = 1 + ($urandom % NUM_PE);
      gap = $urandom % 4;
      mt = 1 + ($urandom % 5);
      mm = -int'($urandom % 5);
      for (int i = 0; i < qlen; i++) qry[i] = $urandom % 4;
      load_query();
      for (int r = 0; r < 4; r++) begin
        sl = 1 + ($urandom % 40);
        for (int j = 0; j < sl; j++) subj[j] = $urandom % 4;
        send(sl, ($urandom % 2) == 1);
        if ($urandom % 2 == 0) begin
          @(negedge clk);
          sub_valid = 1'b0;
          sub_last = 1'b0;
        end
      end
      idle_and_drain();
    end

    check("R3 no stray results", exp_w.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule